// File: doc/BRIEF.md
# Shift-Register Noise Channel

The fourth voice of a square-wave sound generator: a linear feedback shift register that clocks out a pseudo-random bit stream (white mode) or a short repeating pattern (periodic mode). A down-counter that runs on a divided-clock tick enable sets how fast the register advances. The shift interval is one of three fixed rates, or twice the period currently programmed into tone channel 2. The register's bit 0 is the channel's 1-bit output. Volume scaling and mixing happen downstream.

The surrounding logic holds the 3-bit noise control value. It pulses `ctrl_wr_i` when that value is written and raises `mode_chg_i` when the write flips the white/periodic bit. Parameters set the register length, both tap positions and the feedback polarity (XOR or XNOR). A further parameter sets whether every control write restarts the register, or only writes that change the mode.

Top module: `noise_chan`

## Requirements
- R1: With `ctrl_i[1:0]` set to 00, 01 or 10, the register shifts once every 32, 64 or 128 ticks.
- R2: With `ctrl_i[1:0]` = 11, the shift interval is twice `tone2_period_i`, so a value of 0 gives a shift on every tick. A new tone 2 value applies at the next counter reload, and no control write is needed.
- R3: The counter starts at 0 after reset and steps down by one on each cycle that has `tick_i` high. On a tick that takes it to zero or below, the register shifts and the counter reloads with the current interval. Cycles without `tick_i` leave it unchanged.
- R4: A shift moves the register one place toward bit 0 and puts the feedback bit into bit LEN-1.
- R5: When `ctrl_i[2]` = 1 (white), the feedback is the XOR of bits TAP_A and TAP_B. When `ctrl_i[2]` = 0 (periodic), the feedback is bit TAP_A alone, so the register cycles through LEN states.
- R6: `noise_o` is bit 0 of the register.
- R7: With RELOAD_ON_MODE = 0, every cycle with `ctrl_wr_i` high loads the register with a single 1 in bit LEN-1. That load takes priority over a shift in the same cycle, and the counter is not affected.
- R8: With RELOAD_ON_MODE = 1, a control write loads the register only when `mode_chg_i` is high. Any other control write leaves the register unchanged.
- R9: Reset loads the register with a single 1 in bit LEN-1 and clears the counter, so `noise_o` is 0 and the first tick after reset shifts the register.
- R10: With XNOR_FB = 1, white-mode feedback is the inverse of the XOR of the two taps, and periodic-mode feedback is still bit TAP_A alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Divided-clock enable, one cycle per generator step |
| ctrl_i | input | 3 | Noise control: bit 2 selects white mode, bits 1:0 select the rate |
| tone2_period_i | input | PW | Current period of tone channel 2 |
| ctrl_wr_i | input | 1 | Pulses high for one cycle when the control value is written |
| mode_chg_i | input | 1 | High with `ctrl_wr_i` when the write changes bit 2 |
| noise_o | output | 1 | Noise bit |

## Verification
All state sits in two registers, so a tick or a control write sampled at a clock edge shows up on `noise_o` right after that edge. There is no extra pipeline stage. The bench drives inputs on the falling edge and updates a behavioural model at the rising edge from the same inputs. It compares the model against `noise_o` at the next falling edge, exactly one edge after the stimulus. A rate or tone 2 change only takes effect at the next counter reload, and the model's own counter places that reload in the right cycle.

// File: rtl/noise_pkg.sv
package noise_pkg;
  typedef enum logic [1:0] {
    RATE_32   = 2'd0,
    RATE_64   = 2'd1,
    RATE_128  = 2'd2,
    RATE_TONE = 2'd3
  } rate_e;

  localparam int unsigned RATE_BASE_LOG2 = 5;
endpackage

// File: rtl/noise_period_sel.sv
module noise_period_sel
  import noise_pkg::*;
#(
  parameter int unsigned PW = 10,
  parameter int unsigned CW = PW + 1
) (
  input  rate_e          rate_i,
  input  logic [PW-1:0]  tone2_period_i,
  output logic [CW-1:0]  period_o
);
  always_comb begin
    unique case (rate_i)
      RATE_32:   period_o = CW'(1) << RATE_BASE_LOG2;
      RATE_64:   period_o = CW'(1) << (RATE_BASE_LOG2 + 1);
      RATE_128:  period_o = CW'(1) << (RATE_BASE_LOG2 + 2);
      default:   period_o = {tone2_period_i, 1'b0};
    endcase
  end
endmodule

// File: rtl/noise_timer.sv
module noise_timer #(
  parameter int unsigned CW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [CW-1:0] period_i,
  output logic          shift_o
);
  logic [CW-1:0] cnt_q;

  // decrement-then-test: at or below one means the step reaches zero
  assign shift_o = tick_i && (cnt_q <= CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (shift_o) cnt_q <= period_i;
    else if (tick_i)  cnt_q <= cnt_q - CW'(1);
  end

  p_reload_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |=> cnt_q == $past(period_i));
  p_count_down_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !shift_o) |=> cnt_q == $past(cnt_q) - CW'(1));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/noise_lfsr.sv
module noise_lfsr #(
  parameter int unsigned LEN     = 15,
  parameter int unsigned TAP_A   = 0,
  parameter int unsigned TAP_B   = 1,
  parameter bit          XNOR_FB = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic reload_i,
  input  logic white_i,
  output logic bit0_o
);
  localparam logic [LEN-1:0] SEED = {1'b1, {(LEN-1){1'b0}}};

  logic [LEN-1:0] q;
  logic           tap_b_eff;
  logic           fb;

  // periodic mode parks tap B at the value that passes tap A through
  generate
    if (XNOR_FB) begin : g_xnor
      assign tap_b_eff = white_i ? q[TAP_B] : 1'b1;
      assign fb        = ~(q[TAP_A] ^ tap_b_eff);
    end else begin : g_xor
      assign tap_b_eff = white_i ? q[TAP_B] : 1'b0;
      assign fb        = q[TAP_A] ^ tap_b_eff;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= SEED;
    else if (reload_i) q <= SEED;
    else if (shift_i)  q <= {fb, q[LEN-1:1]};
  end

  assign bit0_o = q[0];

  p_seed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> q == SEED);
  p_shift_right_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !reload_i) |=> q[LEN-2:0] == $past(q[LEN-1:1]));
  p_periodic_ring_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !reload_i && !white_i) |=> q[LEN-1] == $past(q[TAP_A]));
  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !reload_i) |=> $stable(q));
endmodule

// File: rtl/noise_chan.sv
module noise_chan
  import noise_pkg::*;
#(
  parameter int unsigned PW             = 10,
  parameter int unsigned LEN            = 15,
  parameter int unsigned TAP_A          = 0,
  parameter int unsigned TAP_B          = 1,
  parameter bit          XNOR_FB        = 1'b0,
  parameter bit          RELOAD_ON_MODE = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [2:0]    ctrl_i,
  input  logic [PW-1:0] tone2_period_i,
  input  logic          ctrl_wr_i,
  input  logic          mode_chg_i,
  output logic          noise_o
);
  localparam int unsigned CW = PW + 1;

  logic [CW-1:0] period;
  logic          shift;
  logic          reload;

  generate
    if (RELOAD_ON_MODE) begin : g_reload_mode
      assign reload = ctrl_wr_i && mode_chg_i;
    end else begin : g_reload_any
      assign reload = ctrl_wr_i;
    end
  endgenerate

  noise_period_sel #(.PW(PW), .CW(CW)) u_period (
    .rate_i         (rate_e'(ctrl_i[1:0])),
    .tone2_period_i (tone2_period_i),
    .period_o       (period)
  );

  noise_timer #(.CW(CW)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .period_i (period),
    .shift_o  (shift)
  );

  noise_lfsr #(
    .LEN(LEN), .TAP_A(TAP_A), .TAP_B(TAP_B), .XNOR_FB(XNOR_FB)
  ) u_lfsr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  (shift),
    .reload_i (reload),
    .white_i  (ctrl_i[2]),
    .bit0_o   (noise_o)
  );

  p_shift_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift |-> tick_i);
endmodule

// File: tb/noise_chan_bench.sv
module noise_chan_bench;
  localparam int PW = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tick_i = 1'b0;
  logic [2:0]    ctrl_i = 3'b000;
  logic [PW-1:0] tone2_period_i = '0;
  logic          ctrl_wr_i = 1'b0;
  logic          mode_chg_i = 1'b0;
  logic          noise_a, noise_b;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int tick_div = 1;
  int tick_ph = 0;
  bit done = 0;
  string tag = "R9";
  logic [2:0] last_ctrl = 3'b000;

  always #5 clk = ~clk;

  // default: 15 bits, taps 0/1, XOR, reload on any write
  noise_chan #(.PW(PW)) u_noise_chan (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .ctrl_i(ctrl_i),
    .tone2_period_i(tone2_period_i), .ctrl_wr_i(ctrl_wr_i),
    .mode_chg_i(mode_chg_i), .noise_o(noise_a));

  // variant: 15 bits, taps 1/5, XNOR, reload on mode change only
  noise_chan #(.PW(PW), .LEN(15), .TAP_A(1), .TAP_B(5), .XNOR_FB(1'b1),
               .RELOAD_ON_MODE(1'b1)) u_noise_chan_alt (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .ctrl_i(ctrl_i),
    .tone2_period_i(tone2_period_i), .ctrl_wr_i(ctrl_wr_i),
    .mode_chg_i(mode_chg_i), .noise_o(noise_b));

  // behavioural reference state
  int sr_a, sr_b, cn_a, cn_b;

  function automatic int interval();
    case (ctrl_i[1:0])
      2'd0: return 32;
      2'd1: return 64;
      2'd2: return 128;
      default: return 2 * int'(tone2_period_i);
    endcase
  endfunction

  function automatic int step_sr(int sr, int ta, int tb, bit xn, bit white);
    int a, b, f;
    a = (sr >> ta) & 1;
    b = white ? ((sr >> tb) & 1) : (xn ? 1 : 0);
    f = xn ? ((a ^ b) ^ 1) : (a ^ b);
    return (sr >> 1) | (f << 14);
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_a = 32'h4000; sr_b = 32'h4000; cn_a = 0; cn_b = 0;
    end else begin
      bit sh_a, sh_b;
      int per;
      per = interval();
      sh_a = 0; sh_b = 0;
      if (tick_i) begin
        cn_a = cn_a - 1;
        if (cn_a <= 0) begin sh_a = 1; cn_a = per; end
        cn_b = cn_b - 1;
        if (cn_b <= 0) begin sh_b = 1; cn_b = per; end
      end
      if (ctrl_wr_i) sr_a = 32'h4000;
      else if (sh_a) sr_a = step_sr(sr_a, 0, 1, 1'b0, ctrl_i[2]);
      if (ctrl_wr_i && mode_chg_i) sr_b = 32'h4000;
      else if (sh_b) sr_b = step_sr(sr_b, 1, 5, 1'b1, ctrl_i[2]);
    end
  end

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      checks++;
      if (noise_a !== sr_a[0]) begin
        failures++;
        $display("FAIL %s R6 default: noise_o=%0b expected %0b at cycle %0d", tag, noise_a, sr_a[0], cycles);
      end
      checks++;
      if (noise_b !== sr_b[0]) begin
        failures++;
        $display("FAIL %s R10 variant: noise_o=%0b expected %0b at cycle %0d", tag, noise_b, sr_b[0], cycles);
      end
    end
  end

  // tick generator: one tick every tick_div cycles
  always @(negedge clk) begin
    if (!rst_ni) begin tick_i <= 1'b0; tick_ph <= 0; end
    else begin
      tick_i <= (tick_ph == 0);
      tick_ph <= (tick_ph + 1 >= tick_div) ? 0 : tick_ph + 1;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected below 190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ctrl(logic [2:0] v, bit chg_ok = 1);
    @(negedge clk);
    ctrl_i = v;
    ctrl_wr_i = 1'b1;
    mode_chg_i = chg_ok && (v[2] != last_ctrl[2]);
    last_ctrl = v;
    @(negedge clk);
    ctrl_wr_i = 1'b0;
    mode_chg_i = 1'b0;
  endtask

  task automatic expect_bit(string t, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: got %0b expected %0b", t, act, exp);
    end
  endtask

  initial begin
    tag = "R9";
    wait_cyc(3);
    expect_bit("R9 reset output default", noise_a, 1'b0);
    expect_bit("R9 reset output variant", noise_b, 1'b0);
    rst_ni = 1'b1;
    wait_cyc(2);
    expect_bit("R9 first tick idle output", noise_a, 1'b0);

    tag = "R6";
    tick_div = 1;
    wait_cyc(600);

    tag = "R1";
    write_ctrl(3'b000); wait_cyc(1200);
    write_ctrl(3'b001); wait_cyc(2000);
    write_ctrl(3'b010); wait_cyc(4000);

    tag = "R3";
    tick_div = 3;
    write_ctrl(3'b000); wait_cyc(3000);
    tick_div = 1;

    tag = "R5";
    write_ctrl(3'b100); wait_cyc(3000);
    write_ctrl(3'b101); wait_cyc(3000);

    tag = "R2";
    tone2_period_i = 10'd5;
    write_ctrl(3'b111); wait_cyc(800);
    tone2_period_i = 10'd2; wait_cyc(600);
    tone2_period_i = 10'd0; wait_cyc(400);
    tone2_period_i = 10'd3;
    write_ctrl(3'b011); wait_cyc(600);

    tag = "R7";
    write_ctrl(3'b111);
    for (int i = 0; i < 40; i++) begin
      wait_cyc(7 + (i % 5));
      write_ctrl((i % 2) ? 3'b111 : 3'b011);
    end
    wait_cyc(200);

    tag = "R8";
    for (int i = 0; i < 30; i++) begin
      wait_cyc(9 + (i % 4));
      write_ctrl(last_ctrl, 1'b0);
      wait_cyc(5);
      write_ctrl({~last_ctrl[2], 2'b11});
    end
    wait_cyc(200);

    tag = "R4";
    tone2_period_i = 10'd1;
    write_ctrl(3'b111); wait_cyc(2000);
    tick_div = 2;
    write_ctrl(3'b011); wait_cyc(1500);

    tag = "R9";
    @(negedge clk); rst_ni = 1'b0;
    wait_cyc(2);
    expect_bit("R9 re-reset default", noise_a, 1'b0);
    expect_bit("R9 re-reset variant", noise_b, 1'b0);
    rst_ni = 1'b1;
    wait_cyc(300);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule